// File: doc/BRIEF.md
# Pipelined Radix-4 Modular Divider

This block computes the modular quotient x = b / a (mod p) for an odd prime p by running a radix-4 binary extended-GCD recurrence. Two magnitude registers, U and V, start at a and p and shrink every cycle. Two cofactor registers, R and S, start at b and 0 and are kept reduced into [0, p). When V reaches zero, U has become 1 and R holds the quotient.

The U/V decision and the R/S cofactor update are split by a pipeline register. The cofactor update in any cycle therefore applies the decision made in the cycle before it. This removes the comparator from the cofactor path, at the cost of one drain cycle at the end. The mirror-image cofactor operations (R-S) and (S-R) share one subtract-and-reduce unit. An XOR mask exchanges its two inputs when the pending step targets S.

A caller pulses `start` with the operands while the block is idle. It then waits for the one-cycle `done` pulse and reads `result`. The inputs must satisfy 1 <= a < p, 0 <= b < p, and p must be an odd prime of at least 3. The start, busy, done and err pins are plain control and status pins, so there is no back-pressure: the result simply stays on `result` until the next accepted start.

Top module: `gf_div_r4`

## Requirements
- R1: A start pulse while idle, with a nonzero, loads the operands and raises busy from the next cycle.
- R2: At done with err low, result is the unique x in [0, p) with x*a mod p = b.
- R3: Each busy cycle performs one U/V step, chosen by the first case that applies, in this order:
  - U mod 4 = 0: U is quartered.
  - U mod 4 = 2: U is halved.
  - V mod 4 = 0: V is quartered.
  - V mod 4 = 2: V is halved.
  - Otherwise the larger of U and V (V when they are equal) is replaced by the difference, quartered if the difference is a multiple of 4 and halved if not.
- R4: The R/S update lags the U/V step by one cycle. After the step that makes V zero, exactly one drain cycle follows. A run of n steps therefore keeps busy high for exactly n+1 cycles.
- R5: R and S stay in [0, p) in every busy cycle.
- R6: done is high for exactly one cycle, and busy is low in that cycle.
- R7: result holds its value from done until the next accepted start.
- R8: start is ignored while busy: the running operation's result and timing are unchanged.
- R9: A start with a = 0 raises done and err in the next cycle, drives result to 0 and never raises busy.
- R10: err is low at the done of a legal operation.
- R11: After reset, busy, done and err are low and result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| a_in | input | W | Divisor a, 1 <= a < p |
| b_in | input | W | Dividend b, 0 <= b < p |
| p_in | input | W | Odd prime modulus |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Set with done when a was zero |
| result | output | W | Quotient b/a mod p, held until next start |

## Verification
Two things share every busy cycle: the R/S cofactor update for the previous decision and the next U/V decision. They collide hardest when consecutive steps alternate between targeting R and targeting S, which flips the operand swap every cycle. The final drain cycle also coincides with the detection of V = 0. Random operands over several small primes and a large one produce long runs of such alternations. The bench judges each run in two ways. It checks the exact busy length, predicted step by step from the case order in R3. It also checks that result times a reduces to b. A wrong lag, a wrong swap or a missing drain cycle breaks one or both of these checks.

// File: rtl/gf_div_pkg.sv
package gf_div_pkg;

  typedef enum logic [1:0] {
    RS_NOP   = 2'd0,
    RS_HALF  = 2'd1,
    RS_QUART = 2'd2
  } rs_shift_e;

  // Pending cofactor step handed from the decision stage to the cofactor stage
  typedef struct packed {
    rs_shift_e shf;   // reduction applied to the selected value
    logic      sub;   // subtract the partner cofactor first
    logic      tgt_s; // 1: step writes S (swap inputs), 0: step writes R
  } rs_cmd_t;

  localparam rs_cmd_t RS_CMD_IDLE = '{shf: RS_NOP, sub: 1'b0, tgt_s: 1'b0};

endpackage

// File: rtl/gf_div_uv.sv
module gf_div_uv
  import gf_div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] u,
  input  logic [W-1:0] v,
  output logic [W-1:0] u_nxt,
  output logic [W-1:0] v_nxt,
  output rs_cmd_t      cmd
);

  logic [W:0]   v_minus_u;
  logic [W-1:0] u_minus_v;
  logic         u_gt_v;
  logic [W-1:0] gap;

  // comparison by subtraction: a borrow out of V-U means U > V
  assign v_minus_u = {1'b0, v} - {1'b0, u};
  assign u_minus_v = u - v;
  assign u_gt_v    = v_minus_u[W];
  assign gap       = u_gt_v ? u_minus_v : v_minus_u[W-1:0];

  always_comb begin
    u_nxt = u;
    v_nxt = v;
    cmd   = RS_CMD_IDLE;
    if (u[1:0] == 2'b00) begin
      u_nxt = u >> 2;
      cmd   = '{shf: RS_QUART, sub: 1'b0, tgt_s: 1'b0};
    end else if (!u[0]) begin
      u_nxt = u >> 1;
      cmd   = '{shf: RS_HALF, sub: 1'b0, tgt_s: 1'b0};
    end else if (v[1:0] == 2'b00) begin
      v_nxt = v >> 2;
      cmd   = '{shf: RS_QUART, sub: 1'b0, tgt_s: 1'b1};
    end else if (!v[0]) begin
      v_nxt = v >> 1;
      cmd   = '{shf: RS_HALF, sub: 1'b0, tgt_s: 1'b1};
    end else begin
      // both odd: the difference is even, low bits pick /4 or /2
      cmd.sub   = 1'b1;
      cmd.tgt_s = !u_gt_v;
      cmd.shf   = gap[1] ? RS_HALF : RS_QUART;
      if (u_gt_v) u_nxt = gap[1] ? (gap >> 1) : (gap >> 2);
      else        v_nxt = gap[1] ? (gap >> 1) : (gap >> 2);
    end
  end

endmodule

// File: rtl/gf_div_rs.sv
module gf_div_rs
  import gf_div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] r,
  input  logic [W-1:0] s,
  input  logic [W-1:0] p,
  input  rs_cmd_t      cmd,
  output logic [W-1:0] r_nxt,
  output logic [W-1:0] s_nxt
);

  localparam int WE = W + 2;

  logic [W-1:0]  swap_mask;
  logic [W-1:0]  op_a;
  logic [W-1:0]  op_b;
  logic [W:0]    diff;
  logic [W-1:0]  x;
  logic [WE-1:0] xe, pe, p2, p3;
  logic [WE-1:0] half_sum, quart_sum;
  logic [W-1:0]  red;
  logic          unused_bits;

  // XOR-controlled exchange of the two cofactors: no operand multiplexer
  assign swap_mask = {W{cmd.tgt_s}} & (r ^ s);
  assign op_a      = r ^ swap_mask;
  assign op_b      = s ^ swap_mask;

  // modular subtraction with a two-way ladder on the sign bit
  assign diff = {1'b0, op_a} - {1'b0, op_b};
  assign x    = !cmd.sub ? op_a :
                diff[W]  ? (diff[W-1:0] + p) : diff[W-1:0];

  assign xe = {2'b00, x};
  assign pe = {2'b00, p};
  assign p2 = pe << 1;
  assign p3 = pe + p2;

  // halving: add p when odd, then shift
  assign half_sum = xe + (x[0] ? pe : '0);

  // quartering: add the multiple of p that clears the two low bits
  always_comb begin
    unique case (x[1:0])
      2'b00:   quart_sum = xe;
      2'b10:   quart_sum = xe + p2;
      default: quart_sum = (x[1] ^ p[1]) ? (xe + pe) : (xe + p3);
    endcase
  end

  assign red = (cmd.shf == RS_HALF) ? half_sum[W:1] : quart_sum[W+1:2];
  assign unused_bits = ^{half_sum[WE-1], half_sum[0], quart_sum[1:0]};

  always_comb begin
    r_nxt = r;
    s_nxt = s;
    if (cmd.shf != RS_NOP) begin
      if (cmd.tgt_s) s_nxt = red;
      else           r_nxt = red;
    end
  end

endmodule

// File: rtl/gf_div_r4.sv
module gf_div_r4
  import gf_div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] p_in,
  output logic         busy,
  output logic         done,
  output logic         err,
  output logic [W-1:0] result
);

  typedef enum logic {ST_IDLE, ST_RUN} state_e;

  state_e       state_q;
  logic [W-1:0] u_q, v_q, r_q, s_q, p_q;
  rs_cmd_t      cmd_q;
  logic         done_q, err_q;

  logic [W-1:0] u_nx, v_nx, r_nx, s_nx;
  rs_cmd_t      cmd_nx;

  gf_div_uv #(.W(W)) u_uv (
    .u     (u_q),
    .v     (v_q),
    .u_nxt (u_nx),
    .v_nxt (v_nx),
    .cmd   (cmd_nx)
  );

  // acts on cmd_q: the decision registered one cycle earlier
  gf_div_rs #(.W(W)) u_rs (
    .r     (r_q),
    .s     (s_q),
    .p     (p_q),
    .cmd   (cmd_q),
    .r_nxt (r_nx),
    .s_nxt (s_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      u_q     <= '0;
      v_q     <= '0;
      r_q     <= '0;
      s_q     <= '0;
      p_q     <= '0;
      cmd_q   <= RS_CMD_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (a_in == '0) begin
              r_q    <= '0;
              done_q <= 1'b1;
              err_q  <= 1'b1;
            end else begin
              u_q     <= a_in;
              v_q     <= p_in;
              r_q     <= b_in;
              s_q     <= '0;
              p_q     <= p_in;
              cmd_q   <= RS_CMD_IDLE;
              err_q   <= 1'b0;
              state_q <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          r_q <= r_nx;
          s_q <= s_nx;
          if (v_q != '0) begin
            u_q   <= u_nx;
            v_q   <= v_nx;
            cmd_q <= cmd_nx;
          end else begin
            // drain cycle: last cofactor step applied above
            cmd_q   <= RS_CMD_IDLE;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state_q == ST_RUN);
  assign done   = done_q;
  assign err    = err_q;
  assign result = r_q;

endmodule

// File: rtl/gf_div_r4_chk.sv
module gf_div_r4_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] a_in,
  input logic         busy,
  input logic         done,
  input logic         err,
  input logic [W-1:0] result,
  input logic [W-1:0] r_q,
  input logic [W-1:0] s_q,
  input logic [W-1:0] p_q,
  input logic [W-1:0] v_q
);

  AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && a_in != '0) |=> busy); // R1

  AST_DRAIN_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && v_q == '0) |=> (done && !busy)); // R4

  AST_COFACTOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (r_q < p_q && s_q < p_q)); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result)); // R7

  AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && a_in == '0) |=> (done && err && !busy && result == '0)); // R9

  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(busy)) |-> !err); // R10

endmodule

bind gf_div_r4 gf_div_r4_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .a_in   (a_in),
  .busy   (busy),
  .done   (done),
  .err    (err),
  .result (result),
  .r_q    (r_q),
  .s_q    (s_q),
  .p_q    (p_q),
  .v_q    (v_q)
);

// File: tb/test_gf_div_r4.sv
module test_gf_div_r4;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0, p_in = '0;
  logic         busy, done, err;
  logic [W-1:0] result;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk; // 125 MHz

  gf_div_r4 #(.W(W)) i_gf_div_r4 (
    .clk, .rst_n, .start, .a_in, .b_in, .p_in,
    .busy, .done, .err, .result
  );

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // number of U/V steps predicted from the case order of R3
  function automatic int steps_of(input longint a, input longint p);
    longint u = a, v = p, d;
    int n = 0;
    while (v != 0) begin
      if (u % 4 == 0)      u = u / 4;
      else if (u % 2 == 0) u = u / 2;
      else if (v % 4 == 0) v = v / 4;
      else if (v % 2 == 0) v = v / 2;
      else if (u > v) begin d = u - v; u = (d % 4 == 0) ? d / 4 : d / 2; end
      else            begin d = v - u; v = (d % 4 == 0) ? d / 4 : d / 2; end
      n++;
    end
    return n;
  endfunction

  // full operation with per-cycle comparison; inject: pulse a second start mid-run
  task automatic run_op(input longint a, input longint b, input longint p,
                        input bit inject);
    int n = steps_of(a, p);
    longint held;
    @(negedge clk);
    start = 1'b1; a_in = W'(a); b_in = W'(b); p_in = W'(p);
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= n + 1; k++) begin
      chk("R1/R4", "busy during run", longint'(busy), 1);
      chk("R6", "done during run", longint'(done), 0);
      if (inject && k == 2) begin
        start = 1'b1; a_in = W'(longint'(1)); b_in = W'(longint'(0)); // R8
      end
      @(negedge clk);
      start = 1'b0;
    end
    chk("R4", "busy after drain", longint'(busy), 0);
    chk("R6", "done pulse", longint'(done), 1);
    chk("R10", "err on legal op", longint'(err), 0);
    chk("R2", "result below p", longint'(result < W'(p)), 1);
    chk(inject ? "R8" : "R2", "result*a mod p",
        (longint'(result) * a) % p, b);
    held = longint'(result);
    repeat (3) begin
      @(negedge clk);
      chk("R6", "done dropped", longint'(done), 0);
      chk("R7", "result held", longint'(result), held);
    end
  endtask

  task automatic finish_up;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_up();
  end

  initial begin
    longint primes [6] = '{3, 5, 7, 13, 65521, 2147483647};
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "busy", longint'(busy), 0);
    chk("R11", "done", longint'(done), 0);
    chk("R11", "err", longint'(err), 0);
    chk("R11", "result", longint'(result), 0);
    rst_n = 1'b1;

    // corner operands
    run_op(1, 6, 7, 1'b0);                 // R2: a=1 gives b
    chk("R2", "a=1 quotient", longint'(result), 6);
    run_op(12, 0, 13, 1'b0);               // R2: b=0 gives 0
    chk("R2", "b=0 quotient", longint'(result), 0);
    run_op(2147483646, 5, 2147483647, 1'b0); // R3: a=p-1
    run_op(2, 1, 3, 1'b0);                 // R3 smallest prime

    // R9: zero divisor
    @(negedge clk);
    start = 1'b1; a_in = '0; b_in = W'(longint'(4)); p_in = W'(longint'(7));
    @(negedge clk);
    start = 1'b0;
    chk("R9", "done", longint'(done), 1);
    chk("R9", "err", longint'(err), 1);
    chk("R9", "busy", longint'(busy), 0);
    chk("R9", "result", longint'(result), 0);
    @(negedge clk);
    chk("R9", "busy stays low", longint'(busy), 0);

    // R8: start during a run has no effect
    run_op(123456, 777, 2147483647, 1'b1);
    run_op(3, 2, 5, 1'b1);

    // R5/R3: random operands over all primes
    foreach (primes[i]) begin
      for (int t = 0; t < 25; t++) begin
        longint a = 1 + longint'($urandom) % (primes[i] - 1);
        longint b = longint'($urandom) % primes[i];
        run_op(a, b, primes[i], 1'b0);
      end
    end
    finish_up();
  end

endmodule